// File: doc/BRIEF.md
# Mode-Configurable SPI Target with Command Tagging

This block is the target side of a four-wire SPI link. An external controller drives the serial clock and an active-low select line. The block turns the serial stream into whole bytes on an internal receive interface, and it sends bytes taken from an internal transmit interface back out on MISO. Clock polarity, clock phase and bit order are set by three configuration inputs. These inputs are meant to change only while select is released.

The serial pins are not used as clocks. Each one passes through a two-stage synchroniser into the system clock domain, and the edges of SCLK are found there. This requires the system clock to run at least four times faster than SCLK. Inside one select window, the first complete byte is tagged as a command and every later byte is tagged as data. When select is released, the window ends. Any partial byte is thrown away, the bit counter clears, and the next window starts again with a command byte. While select is released, MISO is high-impedance.

A transmit byte is fetched at the start of every byte slot. If the internal side has no byte waiting, the slot sends all ones and an underrun strobe fires.

Top module: `spi_tgt_bridge`

## Requirements
- R1: Mode number = {cfg_cpol, cfg_cpha}. MOSI is sampled on the rising SCLK edge when cfg_cpol equals cfg_cpha, and on the falling edge otherwise. MISO changes on the opposite edge. The byte received equals the byte the controller sent in all four modes.
- R2: With cfg_lsb_first = 0, the first bit on the wire is bit 7. With cfg_lsb_first = 1, it is bit 0. This applies to both MOSI and MISO.
- R3: After the 8th sample of a byte, rx_valid is high for exactly one system cycle and rx_data holds the byte.
- R4: rx_is_cmd is 1 for the first byte completed after select falls and 0 for every later byte in the same window.
- R5: Releasing select in the middle of a byte produces no rx_valid. The next window starts at bit 0, and its first byte is tagged as a command.
- R6: spi_miso is high-impedance (z) whenever the synchronised select is released, including after reset.
- R7: A transmit byte is taken when select falls and again after each 8th sample. Each byte taken gives a one-cycle tx_ready pulse, and the byte is sent on MISO in the following slot.
- R8: If tx_valid is low when a byte is due, the slot sends 8'hFF and tx_underrun pulses for one cycle instead of tx_ready.
- R9: While rst is high and after it is released, rx_valid, tx_ready and tx_underrun are 0 until serial activity occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Idle level of SCLK |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_lsb_first | input | 1 | 1: bit 0 first on the wire |
| spi_sclk | input | 1 | Serial clock from the controller |
| spi_csn | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out, z when deselected |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| rx_is_cmd | output | 1 | Byte is the first of its window |
| tx_data | input | 8 | Next byte to send |
| tx_valid | input | 1 | tx_data is available |
| tx_ready | output | 1 | tx_data was taken this cycle |
| tx_underrun | output | 1 | No byte was available; all ones sent |

## Verification
A pin change becomes visible to the logic two system cycles after it happens, because of the synchroniser. A registered output then follows one cycle after that. So a received byte appears about three to four cycles after the 8th sampling edge, and MISO settles about the same time after a shift edge. The bench holds each SCLK half period for eight system cycles. It reads MISO at the last moment before it drives the sampling edge, and it counts strobes with a monitor on the falling clock. It compares receive records, ready counts and underrun counts only after the window has been closed for sixteen cycles, by which time every result is due.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  localparam int UNIT_W_DEF  = 8;
  localparam int SYNC_DEF    = 2;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
  } spi_cfg_t;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= RST_VAL;
          else     pipe[s] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= RST_VAL;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic csn_s,
  input  logic cpol,
  input  logic cpha,
  output logic sel_act,
  output logic sel_start,
  output logic samp_stb,
  output logic shift_stb
);
  logic sclk_q;
  logic csn_q;
  logic rise;
  logic fall;
  logic samp_on_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      csn_q  <= csn_s;
    end
  end

  always_comb begin
    rise         = sclk_s & ~sclk_q;
    fall         = ~sclk_s & sclk_q;
    samp_on_rise = (cpol == cpha);
    sel_act      = ~csn_s;
    sel_start    = ~csn_s & csn_q;
    samp_stb     = sel_act & (samp_on_rise ? rise : fall);
    shift_stb    = sel_act & (samp_on_rise ? fall : rise);
  end
endmodule

// File: rtl/spi_tgt_rx.sv
module spi_tgt_rx #(
  parameter int W     = 8,
  parameter int CNT_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_act,
  input  logic             sel_start,
  input  logic             samp_stb,
  input  logic             mosi_s,
  input  logic             lsb_first,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             byte_done,
  output logic             rx_valid,
  output logic [W-1:0]     rx_data,
  output logic             rx_is_cmd
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0] shreg;
  logic [W-1:0] shreg_nx;
  logic         first_pend;

  always_comb begin
    if (lsb_first) shreg_nx = {mosi_s, shreg[W-1:1]};
    else           shreg_nx = {shreg[W-2:0], mosi_s};
    byte_done = samp_stb && (bit_cnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      first_pend <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_is_cmd  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!sel_act) begin
        bit_cnt    <= '0;
        first_pend <= 1'b0;
      end else begin
        if (sel_start) begin
          bit_cnt    <= '0;
          first_pend <= 1'b1;
        end
        if (samp_stb) begin
          shreg <= shreg_nx;
          if (byte_done) begin
            bit_cnt    <= '0;
            rx_valid   <= 1'b1;
            rx_data    <= shreg_nx;
            rx_is_cmd  <= first_pend;
            first_pend <= 1'b0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_tgt_tx.sv
module spi_tgt_tx #(
  parameter int           W     = 8,
  parameter int           CNT_W = $clog2(W),
  parameter logic [W-1:0] FILL  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_act,
  input  logic             sel_start,
  input  logic             byte_done,
  input  logic             shift_stb,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             lsb_first,
  input  logic [W-1:0]     tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx_underrun,
  output logic             miso_q,
  output logic             miso_en
);
  logic [W-1:0] txsr;
  logic [W-1:0] next_word;
  logic         load;

  function automatic logic pick(input logic [W-1:0] w,
                                input logic [CNT_W-1:0] i,
                                input logic lsb);
    logic [CNT_W-1:0] ri;
    ri = CNT_W'(W - 1) - i;
    return lsb ? w[i] : w[ri];
  endfunction

  always_comb begin
    load      = sel_act && (sel_start || byte_done);
    next_word = tx_valid ? tx_data : FILL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txsr        <= FILL;
      tx_ready    <= 1'b0;
      tx_underrun <= 1'b0;
      miso_q      <= 1'b1;
      miso_en     <= 1'b0;
    end else begin
      tx_ready    <= 1'b0;
      tx_underrun <= 1'b0;
      miso_en     <= sel_act;
      if (load) begin
        txsr        <= next_word;
        miso_q      <= pick(next_word, '0, lsb_first);
        tx_ready    <= tx_valid;
        tx_underrun <= ~tx_valid;
      end else if (shift_stb) begin
        miso_q <= pick(txsr, bit_cnt, lsb_first);
      end
    end
  end
endmodule

// File: rtl/spi_tgt_bridge.sv
module spi_tgt_bridge
  import spi_tgt_pkg::*;
#(
  parameter int UNIT_W      = UNIT_W_DEF,
  parameter int SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              rx_valid,
  output logic [UNIT_W-1:0] rx_data,
  output logic              rx_is_cmd,
  input  logic [UNIT_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_underrun
);
  localparam int CNT_W = $clog2(UNIT_W);

  spi_cfg_t         cfg;
  logic [2:0]       pins_s;
  logic             sel_act;
  logic             sel_start;
  logic             samp_stb;
  logic             shift_stb;
  logic [CNT_W-1:0] bit_cnt;
  logic             byte_done;
  logic             miso_q;
  logic             miso_en;

  assign cfg = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first};

  // pins_s = {sclk, csn, mosi}; select resets released
  spi_tgt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sclk, spi_csn, spi_mosi}),
    .q   (pins_s)
  );

  spi_tgt_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (pins_s[2]),
    .csn_s     (pins_s[1]),
    .cpol      (cfg.cpol),
    .cpha      (cfg.cpha),
    .sel_act   (sel_act),
    .sel_start (sel_start),
    .samp_stb  (samp_stb),
    .shift_stb (shift_stb)
  );

  spi_tgt_rx #(.W(UNIT_W), .CNT_W(CNT_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .sel_act   (sel_act),
    .sel_start (sel_start),
    .samp_stb  (samp_stb),
    .mosi_s    (pins_s[0]),
    .lsb_first (cfg.lsb_first),
    .bit_cnt   (bit_cnt),
    .byte_done (byte_done),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_is_cmd (rx_is_cmd)
  );

  spi_tgt_tx #(.W(UNIT_W), .CNT_W(CNT_W), .FILL({UNIT_W{1'b1}})) u_tx (
    .clk         (clk),
    .rst         (rst),
    .sel_act     (sel_act),
    .sel_start   (sel_start),
    .byte_done   (byte_done),
    .shift_stb   (shift_stb),
    .bit_cnt     (bit_cnt),
    .lsb_first   (cfg.lsb_first),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_underrun (tx_underrun),
    .miso_q      (miso_q),
    .miso_en     (miso_en)
  );

  assign spi_miso = miso_en ? miso_q : 1'bz;
endmodule

// File: rtl/spi_tgt_chk.sv
module spi_tgt_chk (
  input logic clk,
  input logic rst,
  input logic spi_csn,
  input logic rx_valid,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_underrun,
  input logic miso_en
);
  logic [3:0] csn_hist;

  always_ff @(posedge clk) begin
    if (rst) csn_hist <= '0;
    else     csn_hist <= {csn_hist[2:0], spi_csn};
  end

  // R3
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R5
  no_rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (&csn_hist && spi_csn) |-> !rx_valid);

  // R6
  miso_off_chk: assert property (@(posedge clk) disable iff (rst)
    (&csn_hist && spi_csn) |-> !miso_en);

  // R7
  ready_src_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> $past(tx_valid));

  // R8
  underrun_src_chk: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |-> !$past(tx_valid));

  // R8
  fetch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_ready, tx_underrun}));
endmodule

bind spi_tgt_bridge spi_tgt_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .spi_csn     (spi_csn),
  .rx_valid    (rx_valid),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_underrun (tx_underrun),
  .miso_en     (miso_en)
);

// File: tb/spi_tgt_bridge_test.sv
module spi_tgt_bridge_test;
  localparam int H = 8;
  localparam int NV = 8;
  // {mode[1:0], lsb_first, tx_valid, tx_byte[7:0], mosi_byte[7:0]}
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b1, 8'hA5, 8'h3C},
    {2'd1, 1'b0, 1'b1, 8'h81, 8'hC6},
    {2'd2, 1'b0, 1'b1, 8'h0F, 8'h99},
    {2'd3, 1'b0, 1'b1, 8'hE7, 8'h12},
    {2'd0, 1'b1, 1'b1, 8'hC2, 8'hB4},
    {2'd1, 1'b1, 1'b1, 8'h17, 8'h6E},
    {2'd2, 1'b1, 1'b0, 8'h00, 8'hD3},
    {2'd3, 1'b1, 1'b1, 8'h58, 8'h2B}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic spi_sclk = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic rx_valid, rx_is_cmd, tx_ready, tx_underrun;
  logic [7:0] rx_data;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0;

  int checks = 0, fails = 0;
  int cap_n = 0, rdy_n = 0, ur_n = 0;
  logic [7:0] cap_data [32];
  logic       cap_cmd  [32];
  bit done = 0;

  always #10 clk = ~clk;

  spi_tgt_bridge uut (
    .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_is_cmd(rx_is_cmd), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_underrun(tx_underrun)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        cap_data[cap_n % 32] = rx_data;
        cap_cmd[cap_n % 32]  = rx_is_cmd;
        cap_n++;
      end
      if (tx_ready)    rdy_n++;
      if (tx_underrun) ur_n++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // controller side: clock nbits of mo, return bits read from MISO
  task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      int bi;
      bi = cfg_lsb_first ? i : 7 - i;
      if (!cfg_cpha) begin
        spi_mosi = mo[bi];
        tick(H);
        mi[bi] = spi_miso;
        spi_sclk = ~spi_sclk;
        tick(H);
        spi_sclk = ~spi_sclk;
      end else begin
        spi_sclk = ~spi_sclk;
        spi_mosi = mo[bi];
        tick(H);
        mi[bi] = spi_miso;
        spi_sclk = ~spi_sclk;
        tick(H);
      end
    end
  endtask

  task automatic set_mode(input logic [1:0] m, input logic lsb);
    cfg_cpol = m[1];
    cfg_cpha = m[0];
    cfg_lsb_first = lsb;
    spi_sclk = m[1];
    tick(16);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] mi;
    int b_cap, b_rdy, b_ur;
    tick(4);
    // R9 outputs quiet while reset is held
    check(!rx_valid && !tx_ready && !tx_underrun, "R9 in reset", int'(rx_valid), 0);
    rst = 1'b0;
    tick(6);
    check(!rx_valid && !tx_ready && !tx_underrun, "R9 after reset", int'(tx_ready), 0);
    check(spi_miso === 1'bz, "R6 miso z after reset", int'(spi_miso === 1'bz), 1);

    // table of single-byte windows: R1 modes, R2 order, R7/R8 fetch
    for (int v = 0; v < NV; v++) begin
      logic [1:0] m;
      logic lsb, txv;
      logic [7:0] tb, mo, exp_mi;
      {m, lsb, txv, tb, mo} = VEC[v];
      set_mode(m, lsb);
      tx_data = tb;
      tx_valid = txv;
      b_cap = cap_n; b_rdy = rdy_n; b_ur = ur_n;
      spi_csn = 1'b0;
      xfer(mo, 8, mi);
      tick(H);
      spi_csn = 1'b1;
      tick(16);
      exp_mi = txv ? tb : 8'hFF;
      check(cap_n == b_cap + 1, $sformatf("R3 one byte v%0d", v), cap_n - b_cap, 1);
      check(cap_data[b_cap % 32] == mo, $sformatf("R1 R2 rx mode%0d lsb%0d", m, lsb),
            int'(cap_data[b_cap % 32]), int'(mo));
      check(cap_cmd[b_cap % 32] == 1'b1, $sformatf("R4 first is cmd v%0d", v),
            int'(cap_cmd[b_cap % 32]), 1);
      check(mi == exp_mi, $sformatf("R2 R7 R8 miso mode%0d lsb%0d", m, lsb),
            int'(mi), int'(exp_mi));
      check(rdy_n - b_rdy == (txv ? 2 : 0), $sformatf("R7 ready count v%0d", v),
            rdy_n - b_rdy, txv ? 2 : 0);
      check(ur_n - b_ur == (txv ? 0 : 2), $sformatf("R8 underrun count v%0d", v),
            ur_n - b_ur, txv ? 0 : 2);
    end
    tx_valid = 1'b0;

    // R4 multi-byte window in mode 3, MSB first
    set_mode(2'd3, 1'b0);
    tx_data = 8'h3C; tx_valid = 1'b1;
    b_cap = cap_n; b_rdy = rdy_n;
    spi_csn = 1'b0;
    xfer(8'hA1, 8, mi);
    check(mi == 8'h3C, "R7 miso byte 1", int'(mi), 'h3C);
    xfer(8'hB2, 8, mi);
    check(mi == 8'h3C, "R7 miso byte 2", int'(mi), 'h3C);
    xfer(8'hC3, 8, mi);
    tick(H);
    spi_csn = 1'b1;
    tick(16);
    tx_valid = 1'b0;
    check(cap_n == b_cap + 3, "R3 three bytes", cap_n - b_cap, 3);
    check(cap_cmd[b_cap % 32] && !cap_cmd[(b_cap + 1) % 32] && !cap_cmd[(b_cap + 2) % 32],
          "R4 cmd then data", {cap_cmd[b_cap % 32], cap_cmd[(b_cap + 1) % 32],
          cap_cmd[(b_cap + 2) % 32]}, 3'b100);
    check(cap_data[(b_cap + 2) % 32] == 8'hC3, "R3 third byte",
          int'(cap_data[(b_cap + 2) % 32]), 'hC3);
    check(rdy_n - b_rdy == 4, "R7 fetch per slot", rdy_n - b_rdy, 4);

    // R5 abort mid-byte, then a fresh window
    set_mode(2'd0, 1'b0);
    b_cap = cap_n;
    spi_csn = 1'b0;
    xfer(8'hF0, 4, mi);
    tick(H);
    spi_csn = 1'b1;
    tick(16);
    check(cap_n == b_cap, "R5 partial dropped", cap_n - b_cap, 0);
    check(spi_miso === 1'bz, "R6 miso z after abort", int'(spi_miso === 1'bz), 1);
    spi_csn = 1'b0;
    xfer(8'h5A, 8, mi);
    tick(H);
    spi_csn = 1'b1;
    tick(16);
    check(cap_n == b_cap + 1 && cap_data[b_cap % 32] == 8'h5A, "R5 fresh byte",
          int'(cap_data[b_cap % 32]), 'h5A);
    check(cap_cmd[b_cap % 32] == 1'b1, "R5 R4 new window cmd", int'(cap_cmd[b_cap % 32]), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule